// File: doc/BRIEF.md
# Wait-Stated Region Access Controller

This block sits between a processor's load/store port and the memories and register banks of a handheld-style system. It takes one access at a time, works out which target owns the address, and presents a one-hot target select together with the address offset inside that target. The requester is stalled for an externally supplied number of wait clocks. After that the access completes with a response pulse and, for reads, the returned data.

Eight targets are decoded: boot ROM, external work RAM, internal work RAM, the I/O register window, palette RAM, video RAM, sprite attribute RAM and the cartridge space. Some addresses belong to no target: holes in the I/O page, and everything at or above 0x1000_0000. Such an access still spends its wait time but selects nothing. A read from such an address returns the instruction word most recently fetched by the processor. A build parameter can remove the single mirrored I/O register word.

Top module: `bus_access_ctrl`

## Requirements
- R1: Addresses below 0x0200_0000 select boot ROM (tgt_sel bit 0, offset addr[24:0]). Addresses 0x02xx_xxxx select external RAM (bit 1) and 0x03xx_xxxx select internal RAM (bit 2), each with offset addr[23:0]. At most one tgt_sel bit is ever high.
- R2: Addresses 0x05xx_xxxx select palette RAM (bit 4), 0x06xx_xxxx select video RAM (bit 5) and 0x07xx_xxxx select sprite attribute RAM (bit 6), each with offset addr[23:0].
- R3: An address whose bits [31:10] equal those of 0x0400_0000 selects the I/O window (bit 3) with offset addr[9:0].
- R4: When MIRROR_EN is 1, an address with addr[31:24]=0x04 and addr[15:0]=0x0800 selects the I/O window (bit 3) with offset 0x800, whatever addr[23:16] holds. An address such as 0x0400_0802 matches nothing.
- R5: All other addresses select no target (tgt_sel all zero) and raise neither tgt_rd nor tgt_wr. This covers the rest of the 0x04 page and every address at or above 0x1000_0000.
- R6: Below 0x1000_0000, any address with bit 27 set selects the cartridge (bit 7) with offset addr[26:0].
- R7: After an access is accepted (req_valid high while req_ready high), req_ready stays low for exactly W clocks, where W is req_wait, and a W of 0 counts as 1. tgt_sel and tgt_offset stay steady through that time.
- R8: For a read of a decoded target, tgt_rd is high only in the last of the W wait clocks. In the next clock rsp_valid is high and rsp_rdata holds the tgt_rdata value sampled in that last wait clock.
- R9: For a write, tgt_wr is high in the completion clock that follows the W wait clocks, with tgt_wdata equal to the accepted req_wdata.
- R10: Writes that decode to boot ROM never raise tgt_wr. They still complete after W clocks.
- R11: A read that selects no target returns, in rsp_rdata, the fetch_word value present in its last wait clock.
- R12: During and right after reset, req_ready is high and rsp_valid, tgt_rd, tgt_wr and tgt_sel are all zero.
- R13: With MIRROR_EN set to 0, the mirrored register address of R4 selects no target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_wait | input | WAIT_W | Wait clocks for this access (0 means 1) |
| fetch_word | input | DATA_W | Last fetched instruction word, returned by unmapped reads |
| tgt_rdata | input | DATA_W | Read data from the selected target |
| req_ready | output | 1 | High when idle and able to accept |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W | Read result, valid with rsp_valid |
| tgt_sel | output | 8 | One-hot target select |
| tgt_offset | output | 27 | Offset within the selected target |
| tgt_rd | output | 1 | Read strobe to the target |
| tgt_wr | output | 1 | Write strobe to the target |
| tgt_wdata | output | DATA_W | Write data to the target |

## Verification
The bench builds two copies side by side, both with DATA_W=32 and WAIT_W=5. One keeps the mirrored register enabled and the other has MIRROR_EN=0, so a single access to the mirror address shows both decode variants at once. A 5-bit wait field allows counts from 0 up to 31. That covers the zero-means-one rule, a one-clock access where the read strobe falls in the first and only wait clock, and a long stall where the busy length is counted clock by clock.

// File: rtl/bac_pkg.sv
`timescale 1ns/1ps
package bac_pkg;
   localparam int ADDR_W      = 32;
   localparam int NUM_REGIONS = 8;
   localparam int OFF_W       = 27;

   typedef enum logic [2:0] {
      RG_BOOT  = 3'd0,
      RG_XRAM  = 3'd1,
      RG_IRAM  = 3'd2,
      RG_IOREG = 3'd3,
      RG_PAL   = 3'd4,
      RG_VRAM  = 3'd5,
      RG_OAM   = 3'd6,
      RG_CART  = 3'd7
   } region_e;

   typedef struct packed {
      logic             hit;
      region_e          region;
      logic [OFF_W-1:0] offset;
   } decode_t;
endpackage

// File: rtl/bac_decode.sv
`timescale 1ns/1ps
module bac_decode
   import bac_pkg::*;
#(
   parameter bit MIRROR_EN = 1'b1
)(
   input  logic [ADDR_W-1:0] addr,
   output decode_t           dec
);
   logic mir_hit;
   logic io_hit;

   generate
      if (MIRROR_EN) begin : g_mirror
         assign mir_hit = (addr[15:0] == 16'h0800);
      end else begin : g_no_mirror
         assign mir_hit = 1'b0;
      end
   endgenerate

   assign io_hit = (addr[23:10] == 14'd0);

   always_comb begin
      dec = '0;
      if (addr[31:28] != 4'd0) begin
         dec = '0;
      end else if (addr[27]) begin
         dec.hit    = 1'b1;
         dec.region = RG_CART;
         dec.offset = addr[26:0];
      end else begin
         case (addr[26:24])
            3'd0, 3'd1: begin
               dec.hit    = 1'b1;
               dec.region = RG_BOOT;
               dec.offset = {2'b00, addr[24:0]};
            end
            3'd2: begin
               dec.hit    = 1'b1;
               dec.region = RG_XRAM;
               dec.offset = {3'b000, addr[23:0]};
            end
            3'd3: begin
               dec.hit    = 1'b1;
               dec.region = RG_IRAM;
               dec.offset = {3'b000, addr[23:0]};
            end
            3'd4: begin
               if (io_hit) begin
                  dec.hit    = 1'b1;
                  dec.region = RG_IOREG;
                  dec.offset = {17'd0, addr[9:0]};
               end else if (mir_hit) begin
                  dec.hit    = 1'b1;
                  dec.region = RG_IOREG;
                  dec.offset = {15'd0, 10'h200, addr[1:0]};
               end
            end
            3'd5: begin
               dec.hit    = 1'b1;
               dec.region = RG_PAL;
               dec.offset = {3'b000, addr[23:0]};
            end
            3'd6: begin
               dec.hit    = 1'b1;
               dec.region = RG_VRAM;
               dec.offset = {3'b000, addr[23:0]};
            end
            default: begin
               dec.hit    = 1'b1;
               dec.region = RG_OAM;
               dec.offset = {3'b000, addr[23:0]};
            end
         endcase
      end
   end
endmodule

// File: rtl/bac_timer.sv
`timescale 1ns/1ps
module bac_timer #(
   parameter int WAIT_W = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WAIT_W-1:0] wait_in,
   output logic              idle,
   output logic              last,
   output logic              done
);
   localparam logic [WAIT_W-1:0] ONE = WAIT_W'(1);

   logic [WAIT_W-1:0] cnt;
   logic              done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt    <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= (cnt == ONE);
         if (start) begin
            cnt <= (wait_in == '0) ? ONE : wait_in;
         end else if (cnt != '0) begin
            cnt <= cnt - ONE;
         end
      end
   end

   assign idle = (cnt == '0);
   assign last = (cnt == ONE);
   assign done = done_q;
endmodule

// File: rtl/bus_access_ctrl.sv
`timescale 1ns/1ps
module bus_access_ctrl
   import bac_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int WAIT_W    = 5,
   parameter bit MIRROR_EN = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   req_valid,
   input  logic                   req_write,
   input  logic [ADDR_W-1:0]      req_addr,
   input  logic [DATA_W-1:0]      req_wdata,
   input  logic [WAIT_W-1:0]      req_wait,
   input  logic [DATA_W-1:0]      fetch_word,
   input  logic [DATA_W-1:0]      tgt_rdata,
   output logic                   req_ready,
   output logic                   rsp_valid,
   output logic [DATA_W-1:0]      rsp_rdata,
   output logic [NUM_REGIONS-1:0] tgt_sel,
   output logic [OFF_W-1:0]       tgt_offset,
   output logic                   tgt_rd,
   output logic                   tgt_wr,
   output logic [DATA_W-1:0]      tgt_wdata
);
   generate
      if (DATA_W < 8) begin : g_bad_data_w
         $error("bus_access_ctrl: DATA_W must be at least 8");
      end
      if (WAIT_W < 2) begin : g_bad_wait_w
         $error("bus_access_ctrl: WAIT_W must be at least 2");
      end
   endgenerate

   decode_t           dec;
   logic              idle;
   logic              last;
   logic              done;
   logic              accept;

   logic              hit_q;
   region_e           region_q;
   logic [OFF_W-1:0]  off_q;
   logic              write_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;

   bac_decode #(.MIRROR_EN(MIRROR_EN)) u_decode (
      .addr (req_addr),
      .dec  (dec)
   );

   bac_timer #(.WAIT_W(WAIT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .wait_in (req_wait),
      .idle    (idle),
      .last    (last),
      .done    (done)
   );

   assign accept = req_valid && idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_q    <= 1'b0;
         region_q <= RG_BOOT;
         off_q    <= '0;
         write_q  <= 1'b0;
         wdata_q  <= '0;
      end else if (accept) begin
         hit_q    <= dec.hit;
         region_q <= dec.region;
         off_q    <= dec.offset;
         write_q  <= req_write;
         wdata_q  <= req_wdata;
      end else if (done) begin
         hit_q    <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (last && !write_q) begin
         rdata_q <= hit_q ? tgt_rdata : fetch_word;
      end
   end

   generate
      for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_sel
         assign tgt_sel[i] = hit_q && (region_q == region_e'(3'(i)));
      end
   endgenerate

   assign tgt_offset = off_q;
   assign tgt_rd     = last && hit_q && !write_q;
   assign tgt_wr     = done && hit_q && write_q && (region_q != RG_BOOT);
   assign tgt_wdata  = wdata_q;
   assign req_ready  = idle;
   assign rsp_valid  = done;
   assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/bac_checker.sv
`timescale 1ns/1ps
module bac_checker
   import bac_pkg::*;
(
   input logic                   clk,
   input logic                   rst_n,
   input logic                   req_ready,
   input logic                   rsp_valid,
   input logic [NUM_REGIONS-1:0] tgt_sel,
   input logic [OFF_W-1:0]       tgt_offset,
   input logic                   tgt_rd,
   input logic                   tgt_wr
);
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_sel)); // R1
   AST_NULL_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_sel == '0) |-> !(tgt_rd || tgt_wr)); // R5
   AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!req_ready)); // R7
   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_ready && $past(!req_ready)) |-> ($stable(tgt_sel) && $stable(tgt_offset))); // R7
   AST_RD_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rd |-> !req_ready); // R8
   AST_RD_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_rd |=> rsp_valid); // R8
   AST_WR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_wr |-> (rsp_valid && req_ready)); // R9
   AST_NO_BOOT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_wr |-> !tgt_sel[0]); // R10
endmodule

bind bus_access_ctrl bac_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .tgt_sel    (tgt_sel),
   .tgt_offset (tgt_offset),
   .tgt_rd     (tgt_rd),
   .tgt_wr     (tgt_wr)
);

// File: tb/bus_access_ctrl_test.sv
`timescale 1ns/1ps
module bus_access_ctrl_test;
   localparam int DW = 32;
   localparam int WW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [31:0]   req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [WW-1:0] req_wait = '0;
   logic [DW-1:0] fetch_word = '0;
   logic [DW-1:0] tgt_rdata = '0;

   logic          req_ready, rsp_valid, tgt_rd, tgt_wr;
   logic [DW-1:0] rsp_rdata, tgt_wdata;
   logic [7:0]    tgt_sel;
   logic [26:0]   tgt_offset;

   logic          nm_ready, nm_valid, nm_rd, nm_wr;
   logic [DW-1:0] nm_rdata, nm_wdata;
   logic [7:0]    nm_sel;
   logic [26:0]   nm_offset;

   int n_checks = 0;
   int n_fails  = 0;

   always #2.5 clk = ~clk;

   bus_access_ctrl #(.DATA_W(DW), .WAIT_W(WW), .MIRROR_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_wait(req_wait),
      .fetch_word(fetch_word), .tgt_rdata(tgt_rdata),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .tgt_sel(tgt_sel), .tgt_offset(tgt_offset), .tgt_rd(tgt_rd),
      .tgt_wr(tgt_wr), .tgt_wdata(tgt_wdata));

   bus_access_ctrl #(.DATA_W(DW), .WAIT_W(WW), .MIRROR_EN(1'b0)) uut_nomir (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_wait(req_wait),
      .fetch_word(fetch_word), .tgt_rdata(tgt_rdata),
      .req_ready(nm_ready), .rsp_valid(nm_valid), .rsp_rdata(nm_rdata),
      .tgt_sel(nm_sel), .tgt_offset(nm_offset), .tgt_rd(nm_rd),
      .tgt_wr(nm_wr), .tgt_wdata(nm_wdata));

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One access; rg = -1 means no target. nm_null: mirror-less copy must see no target.
   task automatic run_access(input string req, input bit wr, input logic [31:0] addr,
                             input logic [31:0] wd, input int w, input int rg,
                             input logic [26:0] off, input bit nm_null);
      int         weff = (w == 0) ? 1 : w;
      logic [7:0] esel = (rg < 0) ? 8'h00 : 8'(1 << rg);
      int         busy = 0;
      int         rd_at = -1;
      int         rd_cnt = 0;
      int         exp_rd_at;
      logic [31:0] exp_rdata;
      logic [7:0] nm_seen = '0;
      @(negedge clk);
      req_valid  = 1'b1;
      req_write  = wr;
      req_addr   = addr;
      req_wdata  = wd;
      req_wait   = WW'(w);
      fetch_word = 32'hF00D_0000 ^ addr;
      tgt_rdata  = 32'h5A00_0000 ^ {addr[15:0], addr[15:0]};
      @(negedge clk);
      req_valid = 1'b0;
      for (int k = 1; k <= weff; k++) begin
         if (k > 1) @(negedge clk);
         if (!req_ready) busy++;
         if (tgt_rd) begin rd_at = k; rd_cnt++; end
         if (k == weff) begin
            check(req, "tgt_sel", 64'(tgt_sel), 64'(esel));
            if (rg >= 0) check(req, "tgt_offset", 64'(tgt_offset), 64'(off));
            nm_seen = nm_sel;
         end
      end
      if (nm_null) check(req, "no-mirror tgt_sel", 64'(nm_seen), 64'h0);
      @(negedge clk);
      check(req, "busy clocks", 64'(busy), 64'(weff));
      check(req, "req_ready after wait", 64'(req_ready), 64'h1);
      check(req, "rsp_valid", 64'(rsp_valid), 64'h1);
      exp_rd_at = (!wr && rg >= 0) ? weff : -1;
      check(req, "tgt_rd clock", 64'(rd_at), 64'(exp_rd_at));
      check(req, "tgt_rd count", 64'(rd_cnt), 64'((!wr && rg >= 0) ? 1 : 0));
      check(req, "tgt_wr", 64'(tgt_wr), 64'((wr && rg > 0) ? 1 : 0));
      if (wr) check(req, "tgt_wdata", 64'(tgt_wdata), 64'(wd));
      else begin
         exp_rdata = (rg < 0) ? fetch_word : tgt_rdata;
         check(req, "rsp_rdata", 64'(rsp_rdata), 64'(exp_rdata));
      end
      @(negedge clk);
      check(req, "rsp_valid one clock", 64'(rsp_valid), 64'h0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R12", "req_ready in reset", 64'(req_ready), 64'h1);
      check("R12", "rsp_valid in reset", 64'(rsp_valid), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12", "tgt_sel after reset", 64'(tgt_sel), 64'h0);
      check("R12", "strobes after reset", 64'({tgt_rd, tgt_wr}), 64'h0);
      check("R12", "req_ready after reset", 64'(req_ready), 64'h1);
   endtask

   task automatic t_low_regions();   // R1
      run_access("R1", 0, 32'h0000_1234, 0, 3, 0, 27'h000_1234, 0);
      run_access("R1", 0, 32'h01FF_FFFE, 0, 2, 0, 27'h1FF_FFFE, 0);
      run_access("R1", 0, 32'h0200_0010, 0, 6, 1, 27'h000_0010, 0);
      run_access("R1", 0, 32'h02FF_FFFF, 0, 3, 1, 27'h0FF_FFFF, 0);
      run_access("R1", 0, 32'h0300_0004, 0, 1, 2, 27'h000_0004, 0);
   endtask

   task automatic t_video_regions(); // R2
      run_access("R2", 0, 32'h0500_0002, 0, 1, 4, 27'h000_0002, 0);
      run_access("R2", 0, 32'h0601_2345, 0, 2, 5, 27'h001_2345, 0);
      run_access("R2", 0, 32'h0700_0008, 0, 1, 6, 27'h000_0008, 0);
   endtask

   task automatic t_io();            // R3
      run_access("R3", 0, 32'h0400_0000, 0, 1, 3, 27'h000, 0);
      run_access("R3", 0, 32'h0400_03FE, 0, 2, 3, 27'h3FE, 0);
   endtask

   task automatic t_mirror();        // R4, R13
      run_access("R4", 0, 32'h0412_0800, 0, 2, 3, 27'h800, 1);
      run_access("R13", 0, 32'h0400_0800, 0, 1, 3, 27'h800, 1);
      run_access("R4", 0, 32'h0400_0802, 0, 1, -1, 27'h0, 1);
   endtask

   task automatic t_unmapped();      // R5, R11
      run_access("R5", 0, 32'h0400_0400, 0, 2, -1, 27'h0, 1);
      run_access("R11", 0, 32'h1000_0000, 0, 3, -1, 27'h0, 1);
      run_access("R5", 1, 32'hFFFF_FFFC, 32'h1111_2222, 2, -1, 27'h0, 1);
   endtask

   task automatic t_cart();          // R6
      run_access("R6", 0, 32'h0800_0000, 0, 4, 7, 27'h000_0000, 0);
      run_access("R6", 0, 32'h0DFF_FFF0, 0, 5, 7, 27'h5FF_FFF0, 0);
      run_access("R6", 1, 32'h0F00_0001, 32'hCAFE_0001, 3, 7, 27'h700_0001, 0);
   endtask

   task automatic t_wait();          // R7, R8
      run_access("R7", 0, 32'h0300_0100, 0, 0, 2, 27'h100, 0);
      run_access("R7", 0, 32'h0300_0200, 0, 1, 2, 27'h200, 0);
      run_access("R7", 0, 32'h0200_0300, 0, 7, 1, 27'h300, 0);
      run_access("R8", 0, 32'h0600_0040, 0, 31, 5, 27'h40, 0);
   endtask

   task automatic t_writes();        // R9, R10
      run_access("R9", 1, 32'h0200_0020, 32'hDEAD_BEEF, 2, 1, 27'h20, 0);
      run_access("R9", 1, 32'h0400_0004, 32'h0000_ABCD, 1, 3, 27'h4, 0);
      run_access("R10", 1, 32'h0000_0040, 32'h1234_5678, 3, 0, 27'h40, 0);
      run_access("R10", 1, 32'h01FF_FFFC, 32'h8765_4321, 1, 0, 27'h1FF_FFFC, 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      t_reset();
      t_low_regions();
      t_video_regions();
      t_io();
      t_mirror();
      t_unmapped();
      t_cart();
      t_wait();
      t_writes();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule